// File: doc/BRIEF.md
# Sampling ADC Result Buffer

This block is the result-buffer and control side of a sampling analog-to-digital converter. It keeps four independent result queues, one per sample sequencer, each sixteen entries deep. Each queue reports its read pointer, write pointer, empty flag and full flag together in one packed status word. A converter model built into the block supplies the samples. It is a 32-bit linear-congruential noise generator that stands in for real conversions.

A single-cycle trigger pulse pushes one new sample into queue 0, but only while sequencer 0 is enabled. Software reaches the block through a plain 32-bit register port. A read strobe at a queue's pop address removes the oldest entry. Reads at any other address have no side effects. Overflow and underflow are recorded in sticky per-sequencer bits that software clears by writing ones. The interrupt line is high while any raw interrupt bit is also set in the mask register.

Top module: `adc_result_buffer`

## Requirements
- R1: After reset, each of the four status words reads 0x100, all other registers read 0, and the interrupt output is low.
- R2: A status word packs the read pointer in bits 3:0, the write pointer in bits 7:4, the empty flag in bit 8 and the full flag in bit 12. All other bits read 0.
- R3: A push into a full queue drops the sample and sets bit n of the overflow register (0x10). Otherwise the sample is stored at the write pointer, the write pointer advances modulo 16 and empty clears. Full sets if the write pointer then equals the read pointer.
- R4: A pop of an empty queue returns the entry at the read pointer, moves no pointer, and sets bit n of the underflow register (0x18). Otherwise the read pointer advances modulo 16 and full clears. Empty sets if the read pointer then meets the write pointer.
- R5: A trigger while enable bit 0 is clear leaves queue 0, the raw interrupt bits and the noise state unchanged.
- R6: Each accepted trigger first sets noise = noise*314159+1 (mod 2^32; reset value 0). It then pushes 0x200 + noise[18:16] into queue 0.
- R7: Each accepted trigger sets raw interrupt bit 0 (0x04). The interrupt output equals the OR of raw AND mask (0x08). Reading 0x0C returns raw AND mask. Writing 0x0C clears the raw bits written as one.
- R8: Overflow and underflow bits clear when written with one. An event in the same cycle as the clear leaves the bit set.
- R9: Each sequencer window starts at 0x40 + 0x20*n. A write to its mux register (+0x00) stores the value ANDed with 0x33333333. The enable register (0x00) and the mask register (0x08) keep only 4 bits. The control (+0x04), trigger-select (0x14), priority (0x20) and averaging (0x30) registers store the full 32 bits.
- R10: Only a read strobe at window offset +0x08 pops a queue. Status reads leave the pointers unchanged.
- R11: If a pop of queue 0 and an accepted trigger fall in the same cycle, the pop is applied first. A full queue therefore takes the new sample without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig | input | 1 | Sample trigger pulse for sequencer 0 |
| reg_wen | input | 1 | Register write strobe |
| reg_ren | input | 1 | Register read strobe (pops at a pop address) |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the current state |
| irq | output | 1 | Interrupt, high while raw AND mask is nonzero |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a pop of queue 0 and an accepted trigger. The second pair is a write-one-to-clear of a sticky bit and a fresh overflow, underflow or trigger that sets the same bit. Directed cases drive both pairs against a full queue and against a set overflow bit. The random phase drives trigger pulses alongside random pops, status reads and clear writes. After every edge, a bench model updated in the stated order (pop, then writes, then push) predicts each read value and the interrupt level.

// File: rtl/adc_buf_pkg.sv
// Shared constants for the ADC result buffer: sizes, register offsets and
// the packed status word layout. Assumes FIFO_DEPTH is a power of two.
package adc_buf_pkg;
    localparam int SEQ_N      = 4;
    localparam int SEQ_W      = $clog2(SEQ_N);
    localparam int FIFO_DEPTH = 16;
    localparam int PTR_W      = $clog2(FIFO_DEPTH);
    localparam int SMP_W      = 12;
    localparam int ADDR_W     = 12;

    // Global registers
    localparam int A_ENABLE = 'h00;
    localparam int A_RAW    = 'h04;
    localparam int A_MASK   = 'h08;
    localparam int A_MSTAT  = 'h0C;
    localparam int A_OVF    = 'h10;
    localparam int A_TSEL   = 'h14;
    localparam int A_UNF    = 'h18;
    localparam int A_PRIO   = 'h20;
    localparam int A_AVG    = 'h30;

    // Per-sequencer windows
    localparam int WIN_BASE = 'h40;
    localparam int WIN_SH   = 5;
    localparam int WIN_SIZE = 1 << WIN_SH;
    localparam int W_MUX    = 'h00;
    localparam int W_CTL    = 'h04;
    localparam int W_POP    = 'h08;
    localparam int W_STAT   = 'h0C;

    localparam logic [31:0] MUX_KEEP = 32'h3333_3333;
    localparam logic [31:0] LCG_MUL  = 32'd314159;
    localparam logic [11:0] SMP_BASE = 12'h200;

    // Status word bit positions
    localparam int ST_HEAD  = 4;
    localparam int ST_EMPTY = 8;
    localparam int ST_FULL  = 12;

    function automatic logic [31:0] pack_status(input logic [PTR_W-1:0] tl,
                                                input logic [PTR_W-1:0] hd,
                                                input logic emp, input logic ful);
        logic [31:0] w;
        w = '0;
        w[PTR_W-1:0]           = tl;
        w[ST_HEAD +: PTR_W]    = hd;
        w[ST_EMPTY]            = emp;
        w[ST_FULL]             = ful;
        return w;
    endfunction
endpackage

// File: rtl/adc_noise_gen.sv
// Stand-in converter: a 32-bit linear-congruential generator advanced once
// per accepted trigger. The sample is derived from the advanced value.
module adc_noise_gen
    import adc_buf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [SMP_W-1:0] sample
);
    logic [31:0] state_q;
    logic [31:0] nxt;

    // next generator value, 32-bit wrap
    assign nxt    = state_q * LCG_MUL + 32'd1;
    // sample is a base offset plus three bits of the new state
    assign sample = SMP_W'(SMP_BASE + {9'd0, nxt[18:16]});

    // generator state, only advanced when a trigger is accepted
    always_ff @(posedge clk) begin
        if (!rst_n)   state_q <= '0;
        else if (adv) state_q <= nxt;
    end
endmodule

// File: rtl/adc_seq_fifo.sv
// One result queue with explicit head/tail pointers and empty/full flags.
// A pop and a push in the same cycle are ordered pop first. Storage is reset
// so a dry pop after reset returns zero. Assumes DEPTH is a power of two.
module adc_seq_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 12,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] rd_data,
    output logic [PW-1:0] head,
    output logic [PW-1:0] tail,
    output logic          empty,
    output logic          full,
    output logic          ovf_evt,
    output logic          unf_evt
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] head_q, tail_q, head_n, tail_n;
    logic          empty_q, full_q, empty_n, full_n, wr_ok;

    assign rd_data = mem[tail_q];
    assign head    = head_q;
    assign tail    = tail_q;
    assign empty   = empty_q;
    assign full    = full_q;

    // next pointers and flags: pop applied first, then push
    always_comb begin
        head_n  = head_q;
        tail_n  = tail_q;
        empty_n = empty_q;
        full_n  = full_q;
        unf_evt = 1'b0;
        ovf_evt = 1'b0;
        wr_ok   = 1'b0;
        if (pop) begin
            if (empty_q) unf_evt = 1'b1;
            else begin
                tail_n = tail_q + 1'b1;
                full_n = 1'b0;
                if (tail_n == head_q) empty_n = 1'b1;
            end
        end
        if (push) begin
            if (full_n) ovf_evt = 1'b1;
            else begin
                wr_ok   = 1'b1;
                head_n  = head_q + 1'b1;
                empty_n = 1'b0;
                if (head_n == tail_n) full_n = 1'b1;
            end
        end
    end

    // pointer and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            empty_q <= 1'b1;
            full_q  <= 1'b0;
        end else begin
            head_q  <= head_n;
            tail_q  <= tail_n;
            empty_q <= empty_n;
            full_q  <= full_n;
        end
    end

    // sample storage, written at the old head when there is room
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_ok) begin
            mem[head_q] <= push_data;
        end
    end
endmodule

// File: rtl/adc_result_buffer.sv
// Result buffer of a four-sequencer sampling ADC. Decodes a flat 32-bit
// register port, holds control, interrupt and sticky error registers, and
// routes trigger samples into queue 0. Read data is combinational; pops and
// writes take effect at the clock edge that ends the strobe cycle.
module adc_result_buffer
    import adc_buf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              reg_wen,
    input  logic              reg_ren,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    logic [SEQ_N-1:0] en_q, im_q, ris_q, ovf_q, unf_q;
    logic [31:0]      tsel_q, prio_q, avg_q;
    logic [31:0]      mux_q [SEQ_N];
    logic [31:0]      ctl_q [SEQ_N];
    logic [31:0]      stat_w [SEQ_N];
    logic [SMP_W-1:0] fifo_rd [SEQ_N];
    logic [SEQ_N-1:0] pop_v, ovf_ev, unf_ev;
    logic [SMP_W-1:0] smp;
    logic             accept, in_win;
    logic [SEQ_W-1:0] seq_idx;
    logic [4:0]       sub;
    logic [SEQ_N-1:0] clr_ris, clr_ovf, clr_unf;

    // window decode
    assign in_win  = (reg_addr >= ADDR_W'(WIN_BASE)) &&
                     (reg_addr <  ADDR_W'(WIN_BASE + SEQ_N * WIN_SIZE));
    assign seq_idx = SEQ_W'((reg_addr - ADDR_W'(WIN_BASE)) >> WIN_SH);
    assign sub     = reg_addr[4:0];
    assign accept  = trig && en_q[0];

    adc_noise_gen u_noise (
        .clk(clk), .rst_n(rst_n), .adv(accept), .sample(smp)
    );

    for (genvar g = 0; g < SEQ_N; g++) begin : g_seq
        logic [PTR_W-1:0] hd, tl;
        logic             em, fu, psh;

        assign pop_v[g] = reg_ren && in_win && (seq_idx == SEQ_W'(g)) &&
                          (sub == 5'(W_POP));
        if (g == 0) begin : g_fed
            assign psh = accept;
        end else begin : g_idle
            assign psh = 1'b0;
        end

        adc_seq_fifo #(.DEPTH(FIFO_DEPTH), .DW(SMP_W)) u_fifo (
            .clk(clk), .rst_n(rst_n), .push(psh), .push_data(smp),
            .pop(pop_v[g]), .rd_data(fifo_rd[g]), .head(hd), .tail(tl),
            .empty(em), .full(fu), .ovf_evt(ovf_ev[g]), .unf_evt(unf_ev[g])
        );
        assign stat_w[g] = pack_status(tl, hd, em, fu);

        // per-window mux and control registers
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mux_q[g] <= '0;
                ctl_q[g] <= '0;
            end else if (reg_wen && in_win && seq_idx == SEQ_W'(g)) begin
                if (sub == 5'(W_MUX)) mux_q[g] <= reg_wdata & MUX_KEEP;
                if (sub == 5'(W_CTL)) ctl_q[g] <= reg_wdata;
            end
        end
    end

    // write-one-to-clear masks for the sticky registers
    always_comb begin
        clr_ris = '0;
        clr_ovf = '0;
        clr_unf = '0;
        if (reg_wen && !in_win) begin
            if (reg_addr == ADDR_W'(A_MSTAT)) clr_ris = reg_wdata[SEQ_N-1:0];
            if (reg_addr == ADDR_W'(A_OVF))   clr_ovf = reg_wdata[SEQ_N-1:0];
            if (reg_addr == ADDR_W'(A_UNF))   clr_unf = reg_wdata[SEQ_N-1:0];
        end
    end

    // global registers; a same-cycle event wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            im_q   <= '0;
            ris_q  <= '0;
            ovf_q  <= '0;
            unf_q  <= '0;
            tsel_q <= '0;
            prio_q <= '0;
            avg_q  <= '0;
        end else begin
            ris_q <= (ris_q & ~clr_ris) | SEQ_N'(accept);
            ovf_q <= (ovf_q & ~clr_ovf) | ovf_ev;
            unf_q <= (unf_q & ~clr_unf) | unf_ev;
            if (reg_wen) begin
                case (reg_addr)
                    ADDR_W'(A_ENABLE): en_q   <= reg_wdata[SEQ_N-1:0];
                    ADDR_W'(A_MASK):   im_q   <= reg_wdata[SEQ_N-1:0];
                    ADDR_W'(A_TSEL):   tsel_q <= reg_wdata;
                    ADDR_W'(A_PRIO):   prio_q <= reg_wdata;
                    ADDR_W'(A_AVG):    avg_q  <= reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    // read mux, free of side effects
    always_comb begin
        reg_rdata = '0;
        if (in_win) begin
            case (sub)
                5'(W_MUX):  reg_rdata = mux_q[seq_idx];
                5'(W_CTL):  reg_rdata = ctl_q[seq_idx];
                5'(W_POP):  reg_rdata = 32'(fifo_rd[seq_idx]);
                5'(W_STAT): reg_rdata = stat_w[seq_idx];
                default:    reg_rdata = '0;
            endcase
        end else begin
            case (reg_addr)
                ADDR_W'(A_ENABLE): reg_rdata = 32'(en_q);
                ADDR_W'(A_RAW):    reg_rdata = 32'(ris_q);
                ADDR_W'(A_MASK):   reg_rdata = 32'(im_q);
                ADDR_W'(A_MSTAT):  reg_rdata = 32'(ris_q & im_q);
                ADDR_W'(A_OVF):    reg_rdata = 32'(ovf_q);
                ADDR_W'(A_TSEL):   reg_rdata = tsel_q;
                ADDR_W'(A_UNF):    reg_rdata = 32'(unf_q);
                ADDR_W'(A_PRIO):   reg_rdata = prio_q;
                ADDR_W'(A_AVG):    reg_rdata = avg_q;
                default:           reg_rdata = '0;
            endcase
        end
    end

    assign irq = |(ris_q & im_q);
endmodule

// File: rtl/adc_result_buffer_chk.sv
// Assertion checker for queue 0 and the sticky registers of the result
// buffer. Attached to every instance of the top module by a bind.
module adc_result_buffer_chk
    import adc_buf_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        trig,
    input logic        en0,
    input logic        pop0,
    input logic [31:0] stat0,
    input logic        ris0,
    input logic        ovf0,
    input logic        unf0
);
    logic push0, full0, empty0;
    assign push0  = trig && en0;
    assign full0  = stat0[ST_FULL];
    assign empty0 = stat0[ST_EMPTY];

    // R2
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty0 && full0));
    // R3
    no_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push0 && full0 && !pop0) |=> ovf0);
    // R4
    dry_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop0 && empty0) |=> (unf0 && $stable(stat0[PTR_W-1:0])));
    // R5
    trig_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !en0 && !pop0) |=> $stable(stat0));
    // R7
    ris_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push0 |=> ris0);
    // R10
    idle_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pop0 |=> $stable(stat0[PTR_W-1:0]));
endmodule

bind adc_result_buffer adc_result_buffer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .trig(trig), .en0(en_q[0]), .pop0(pop_v[0]),
    .stat0(stat_w[0]), .ris0(ris_q[0]), .ovf0(ovf_q[0]), .unf0(unf_q[0])
);

// File: tb/sim_adc_result_buffer.sv
// Bench for adc_result_buffer: directed corner cases followed by seeded
// random traffic, every read and the interrupt compared with a bench model.
module sim_adc_result_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0, reg_wen = 1'b0, reg_ren = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int nchk = 0, nfail = 0;
    bit done = 0;
    logic [31:0] last_rd;

    // model state
    logic [31:0] m_mem [4][16];
    int          m_hd [4], m_tl [4];
    bit          m_em [4], m_fu [4];
    logic [3:0]  m_en, m_im, m_ris, m_ovf, m_unf;
    logic [31:0] m_mux [4], m_ctl [4], m_tsel, m_prio, m_avg, m_noise;

    always #10 clk = ~clk;

    adc_result_buffer u0 (
        .clk(clk), .rst_n(rst_n), .trig(trig), .reg_wen(reg_wen),
        .reg_ren(reg_ren), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit in_win(input logic [11:0] a);
        return a >= 12'h40 && a < 12'hC0;
    endfunction

    function automatic logic [31:0] m_stat(input int n);
        return 32'(m_tl[n]) | (32'(m_hd[n]) << 4) | (32'(m_em[n]) << 8) |
               (32'(m_fu[n]) << 12);
    endfunction

    function automatic logic [31:0] m_read(input logic [11:0] a);
        int n;
        if (in_win(a)) begin
            n = int'((a - 12'h40) >> 5);
            case (a[4:0])
                5'h00: return m_mux[n];
                5'h04: return m_ctl[n];
                5'h08: return m_mem[n][m_tl[n]];
                5'h0C: return m_stat(n);
                default: return 0;
            endcase
        end
        case (a)
            12'h00: return 32'(m_en);
            12'h04: return 32'(m_ris);
            12'h08: return 32'(m_im);
            12'h0C: return 32'(m_ris & m_im);
            12'h10: return 32'(m_ovf);
            12'h14: return m_tsel;
            12'h18: return 32'(m_unf);
            12'h20: return m_prio;
            12'h30: return m_avg;
            default: return 0;
        endcase
    endfunction

    task automatic m_reset();
        for (int n = 0; n < 4; n++) begin
            for (int i = 0; i < 16; i++) m_mem[n][i] = 0;
            m_hd[n] = 0; m_tl[n] = 0; m_em[n] = 1; m_fu[n] = 0;
            m_mux[n] = 0; m_ctl[n] = 0;
        end
        m_en = 0; m_im = 0; m_ris = 0; m_ovf = 0; m_unf = 0;
        m_tsel = 0; m_prio = 0; m_avg = 0; m_noise = 0;
    endtask

    // model of one clock edge: pop, then writes, then the trigger push
    task automatic m_update(input bit ren, input bit wen, input logic [11:0] a,
                            input logic [31:0] d, input bit tg);
        logic [3:0] old_en, oset, uset;
        int n;
        old_en = m_en; oset = 0; uset = 0;
        if (ren && in_win(a) && a[4:0] == 5'h08) begin
            n = int'((a - 12'h40) >> 5);
            if (m_em[n]) uset[n] = 1'b1;
            else begin
                m_tl[n] = (m_tl[n] + 1) % 16; m_fu[n] = 0;
                if (m_tl[n] == m_hd[n]) m_em[n] = 1;
            end
        end
        if (wen) begin
            if (in_win(a)) begin
                n = int'((a - 12'h40) >> 5);
                if (a[4:0] == 5'h00) m_mux[n] = d & 32'h3333_3333;
                if (a[4:0] == 5'h04) m_ctl[n] = d;
            end else case (a)
                12'h00: m_en = d[3:0];
                12'h08: m_im = d[3:0];
                12'h0C: m_ris = m_ris & ~d[3:0];
                12'h10: m_ovf = m_ovf & ~d[3:0];
                12'h14: m_tsel = d;
                12'h18: m_unf = m_unf & ~d[3:0];
                12'h20: m_prio = d;
                12'h30: m_avg = d;
                default: ;
            endcase
        end
        if (tg && old_en[0]) begin
            m_noise = m_noise * 32'd314159 + 32'd1;
            if (m_fu[0]) oset[0] = 1'b1;
            else begin
                m_mem[0][m_hd[0]] = 32'h200 + ((m_noise >> 16) & 32'h7);
                m_hd[0] = (m_hd[0] + 1) % 16; m_em[0] = 0;
                if (m_hd[0] == m_tl[0]) m_fu[0] = 1;
            end
            m_ris[0] = 1'b1;
        end
        m_ovf = m_ovf | oset;
        m_unf = m_unf | uset;
    endtask

    // one bus cycle; read value sampled before the edge, irq after it
    task automatic cyc(input bit ren, input bit wen, input logic [11:0] a,
                       input logic [31:0] d, input bit tg, input string tag);
        @(negedge clk);
        reg_ren = ren; reg_wen = wen; reg_addr = a; reg_wdata = d; trig = tg;
        #1;
        if (ren) begin
            last_rd = reg_rdata;
            chk({tag, " read"}, reg_rdata, m_read(a));
        end
        @(posedge clk);
        m_update(ren, wen, a, d, tg);
        #1;
        reg_ren = 0; reg_wen = 0; trig = 0;
        chk({tag, " irq"}, 32'(irq), 32'(|(m_ris & m_im)));
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        cyc(1, 0, a, 0, 0, tag);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
        cyc(0, 1, a, d, 0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        nchk++; nfail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        m_reset();
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        for (int n = 0; n < 4; n++) begin
            rd(12'(12'h4C + n * 32), "R1 status");
            chk("R1 status literal", last_rd, 32'h100);
        end
        rd(12'h00, "R1 enable"); chk("R1 enable literal", last_rd, 0);
        rd(12'h60, "R1 mux1");   chk("R1 mux literal", last_rd, 0);
        chk("R1 irq", 32'(irq), 0);

        // R5 trigger while disabled
        cyc(0, 0, 0, 0, 1, "R5 trig off");
        rd(12'h4C, "R5 status"); chk("R5 status literal", last_rd, 32'h100);
        rd(12'h04, "R5 raw");    chk("R5 raw literal", last_rd, 0);

        // R9 masked and full-width register writes
        wr(12'h60, 32'hFFFF_FFFF, "R9 mux");
        rd(12'h60, "R9 mux"); chk("R9 mux literal", last_rd, 32'h3333_3333);
        wr(12'h84, 32'hDEAD_BEEF, "R9 ctl");
        rd(12'h84, "R9 ctl"); chk("R9 ctl literal", last_rd, 32'hDEAD_BEEF);
        wr(12'h20, 32'h1234_5678, "R9 prio");
        rd(12'h20, "R9 prio");
        wr(12'h00, 32'hFF, "R9 enable");
        rd(12'h00, "R9 enable"); chk("R9 enable literal", last_rd, 32'hF);

        // R7 interrupt path
        wr(12'h08, 1, "R7 mask");
        cyc(0, 0, 0, 0, 1, "R7 trig");
        chk("R7 irq high", 32'(irq), 1);
        rd(12'h0C, "R7 masked"); chk("R7 masked literal", last_rd, 1);
        wr(12'h0C, 1, "R7 clear");
        chk("R7 irq low", 32'(irq), 0);

        // R6 sample values: noise 1 -> 0x200, noise 314160 -> 0x204
        cyc(0, 0, 0, 0, 1, "R6 trig");
        rd(12'h48, "R6 pop1"); chk("R6 first sample", last_rd, 32'h200);
        rd(12'h48, "R6 pop2"); chk("R6 second sample", last_rd, 32'h204);

        // R4 dry pops and R10 side-effect-free status reads
        rd(12'h48, "R4 dry pop");
        rd(12'h4C, "R4 status"); chk("R4 status literal", last_rd, 32'h122);
        rd(12'h88, "R4 dry pop seq2");
        rd(12'h18, "R4 unf"); chk("R4 unf literal", last_rd, 32'h5);
        wr(12'h18, 32'h4, "R8 unf clear");
        rd(12'h18, "R8 unf"); chk("R8 unf literal", last_rd, 32'h1);
        for (int i = 0; i < 3; i++) begin
            rd(12'h4C, "R10 status"); chk("R10 status literal", last_rd, 32'h122);
        end

        // R3 fill to full, then overflow
        for (int i = 0; i < 16; i++) cyc(0, 0, 0, 0, 1, "R3 fill");
        rd(12'h4C, "R3 full"); chk("R2 R3 full literal", last_rd, 32'h1022);
        cyc(0, 0, 0, 0, 1, "R3 overflow");
        rd(12'h10, "R3 ovf"); chk("R3 ovf literal", last_rd, 1);
        rd(12'h4C, "R3 after"); chk("R3 unchanged literal", last_rd, 32'h1022);

        // R11 pop and trigger in the same cycle on a full queue
        wr(12'h10, 1, "R8 ovf clear");
        cyc(1, 0, 12'h48, 0, 1, "R11 pop+trig");
        rd(12'h10, "R11 ovf"); chk("R11 no overflow", last_rd, 0);
        rd(12'h4C, "R11 status"); chk("R11 status literal", last_rd, 32'h1033);

        // R8 clear and overflow in the same cycle
        cyc(0, 1, 12'h10, 1, 1, "R8 clear+ovf");
        rd(12'h10, "R8 ovf"); chk("R8 set wins", last_rd, 1);

        // random traffic against the model (all requirements)
        for (int i = 0; i < 1500; i++) begin
            int op, n;
            bit tg;
            logic [11:0] ga;
            op = int'($urandom % 8);
            n  = int'($urandom % 4);
            tg = bit'($urandom % 2);
            case (op)
                0, 1, 2: cyc(1, 0, 12'(12'h48 + n * 32), 0, tg, "RND pop");
                3: cyc(1, 0, 12'(12'h4C + n * 32), 0, tg, "RND status");
                4: cyc(0, 1, 12'h00, {$urandom} | (($urandom % 4 == 0) ? 0 : 1), tg, "RND en");
                5: begin
                    ga = (n == 0) ? 12'h0C : (n == 1) ? 12'h10 : (n == 2) ? 12'h18 : 12'h08;
                    cyc(0, 1, ga, $urandom, tg, "RND w1c");
                end
                6: begin
                    ga = 12'(n * 4 + 4);
                    cyc(1, 0, ga, 0, tg, "RND global");
                end
                default: cyc(0, 0, 0, 0, tg, "RND idle");
            endcase
        end
        finish_run();
    end
endmodule